// File: doc/BRIEF.md
# Ethernet Transmit Graceful-Stop Sequencer

This block takes frame bytes from an upstream source over a valid/ready handshake, with start-of-frame and end-of-frame markers, and shifts them onto a one-bit transmit line. Each byte goes out least significant bit first, and `tx_en` marks the bit times that carry data. Preamble, CRC, backoff and retry belong to the logic around this block.

A level-sensitive stop request lets software pause the transmitter without cutting a frame. If no frame is on the line, the stop takes effect at once. If a frame is on the line, the stop waits until the frame's last bit has gone out or a collision has ended the frame. A single `stop_done` pulse marks the moment the line is actually quiet. While the transmitter is stopped it refuses new bytes. When the request is removed, it starts again with the next frame the source offers.

A collision ends the frame immediately. `drop_ack` then tells the source to throw away the rest of that frame. Frames longer than the programmed maximum raise a one-cycle `oversize` flag, but every byte is still transmitted.

Top module: `eth_tx_gstop`

## Requirements
- R1: While reset is held and right after it, `tx_en`, `stop_done`, `oversize` and `drop_ack` are 0, and `in_ready` equals the inverse of `stop_req`.
- R2: Each accepted byte appears on `tx_d` bit 0 first, over 8 consecutive cycles with `tx_en` high. The first bit appears in the cycle after the start-of-frame byte is accepted. Bytes that arrive in time follow each other with no gap, so a frame of N bytes occupies exactly 8*N cycles of `tx_en`.
- R3: A stop request raised while no frame is active produces `stop_done` in the next cycle. From then on `in_ready` is 0 and no frame starts.
- R4: A stop request raised during a frame lets the whole frame go out. `stop_done` is high in the cycle right after the frame's last `tx_en` cycle.
- R5: `stop_done` is a one-cycle pulse. It fires only once per request, however long the request stays high.
- R6: While stopped, `in_ready` is 0. One cycle after `stop_req` falls, `in_ready` is 1 again and the next start-of-frame byte begins a new frame.
- R7: A byte is numbered k, counting from 1 at the start-of-frame byte. When k first exceeds `max_len`, `oversize` is high for one cycle: the cycle carrying that byte's first bit. It fires once per frame, and the frame is still sent in full. The byte count saturates at its maximum value.
- R8: A `col` high during an active frame ends that frame. In the next cycle `tx_en` is 0 and `drop_ack` is high for one cycle. `col` outside a frame has no effect and produces no `drop_ack`.
- R9: When a stop request is pending and a collision ends the frame, `stop_done` and `drop_ack` are both high in the cycle after the collision.
- R10: Bytes without the start-of-frame marker that are offered while no frame is active are accepted and discarded, and they produce no `tx_en`.
- R11: If the next byte of a frame is late, `tx_en` stays low and `in_ready` stays high until the byte arrives. The frame then continues, and its bytes stay intact and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_req | input | 1 | Graceful stop request (level) |
| max_len | input | 11 | Largest frame length, in bytes, that is not flagged |
| col | input | 1 | Collision seen on the medium |
| in_valid | input | 1 | Source byte valid |
| in_data | input | 8 | Source byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Block accepts the offered byte |
| tx_d | output | 1 | Serial transmit bit |
| tx_en | output | 1 | `tx_d` carries frame data |
| stop_done | output | 1 | One-cycle pulse: the transmitter has stopped |
| oversize | output | 1 | One-cycle pulse: the frame exceeded `max_len` |
| drop_ack | output | 1 | One-cycle pulse: discard the rest of the current frame |

## Verification
Every result is due a fixed number of cycles after its cause. The first bit follows the accepting edge by one cycle, and `stop_done`, `drop_ack` and the off-state of `tx_en` each follow the deciding edge by one cycle. `oversize` coincides with the first bit of the offending byte. The bench drives inputs on falling edges and reads outputs one time step after a falling edge, so each result is read in the cycle where it is due. A monitor stamps every serial bit, pulse and cycle number, and the checks compare these stamps with cycle counts worked out from the frame length, the gap length and the moment the request was raised. Each frame length from 1 to 6 is swept against each maximum from 0 to 6, and the expected `oversize` bit position is computed as 8 times the maximum.

// File: rtl/eth_tx_gstop.sv
module eth_tx_gstop #(
  parameter int LEN_W  = 11,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_req,
  input  logic [LEN_W-1:0]  max_len,
  input  logic              col,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              in_ready,
  output logic              tx_d,
  output logic              tx_en,
  output logic              stop_done,
  output logic              oversize,
  output logic              drop_ack
);

  localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);
  localparam logic [LEN_W-1:0] CNT_MAX  = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_HALT} st_t;

  st_t               st, st_nxt;
  logic [BYTE_W-1:0] sh;
  logic [BIT_W-1:0]  bpos;
  logic              have, last, flagged;
  logic [LEN_W-1:0]  cnt, cnt_nxt;

  wire in_send    = (st == ST_SEND);
  wire at_end     = have && (bpos == BIT_LAST);
  wire frame_done = in_send && (col || (at_end && last));

  assign in_ready = ((st == ST_IDLE) && !stop_req) ||
                    (in_send && !col && !last && (!have || at_end));

  wire take  = in_valid && in_ready;
  wire start = (st == ST_IDLE) && take && in_sof;
  wire load  = start || (in_send && take);

  assign cnt_nxt = start ? LEN_W'(1) : ((cnt == CNT_MAX) ? cnt : cnt + LEN_W'(1));
  wire   too_long = (cnt_nxt > max_len) && (start || !flagged);

  assign tx_en = in_send && have;
  assign tx_d  = sh[0];

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE: if (stop_req)   st_nxt = ST_HALT;
               else if (start) st_nxt = ST_SEND;
      ST_SEND: if (frame_done) st_nxt = stop_req ? ST_HALT : ST_IDLE;
      ST_HALT: if (!stop_req)  st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sh        <= '0;
      bpos      <= '0;
      have      <= 1'b0;
      last      <= 1'b0;
      flagged   <= 1'b0;
      cnt       <= '0;
      stop_done <= 1'b0;
      oversize  <= 1'b0;
      drop_ack  <= 1'b0;
    end else begin
      st        <= st_nxt;
      stop_done <= (st_nxt == ST_HALT) && (st != ST_HALT);
      drop_ack  <= in_send && col;
      oversize  <= 1'b0;
      if (load) begin
        sh   <= in_data;
        bpos <= '0;
        have <= 1'b1;
        last <= in_eof;
        cnt  <= cnt_nxt;
        if (too_long) begin
          oversize <= 1'b1;
          flagged  <= 1'b1;
        end else if (start) begin
          flagged  <= 1'b0;
        end
      end else if (tx_en) begin
        sh <= sh >> 1;
        if (at_end) have <= 1'b0;
        else        bpos <= bpos + BIT_W'(1);
      end
      if (frame_done) begin
        have <= 1'b0;
        last <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/eth_tx_gstop_chk.sv
module eth_tx_gstop_chk (
  input logic clk,
  input logic rst_n,
  input logic col,
  input logic in_ready,
  input logic tx_en,
  input logic stop_done,
  input logic oversize,
  input logic drop_ack
);

  AST_STOP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> !stop_done); // R5

  AST_HALTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |-> (!in_ready && !tx_en)); // R6

  AST_COLLISION_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (col && tx_en) |=> (!tx_en && drop_ack)); // R8

  AST_DROP_NEEDS_COL: assert property (@(posedge clk) disable iff (!rst_n)
    !col |=> !drop_ack); // R8

  AST_OVERSIZE_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    oversize |-> tx_en); // R7

  AST_OVERSIZE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    oversize |=> !oversize); // R7

endmodule

bind eth_tx_gstop eth_tx_gstop_chk u_chk (
  .clk(clk), .rst_n(rst_n), .col(col), .in_ready(in_ready), .tx_en(tx_en),
  .stop_done(stop_done), .oversize(oversize), .drop_ack(drop_ack)
);

// File: tb/sim_eth_tx_gstop.sv
`timescale 1ns/1ps
module sim_eth_tx_gstop;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stop_req = 1'b0;
  logic [10:0] max_len = 11'd100;
  logic        col = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic        in_ready, tx_d, tx_en, stop_done, oversize, drop_ack;

  always #2.5 clk = ~clk;

  eth_tx_gstop u0 (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .max_len(max_len), .col(col),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_ready(in_ready), .tx_d(tx_d), .tx_en(tx_en), .stop_done(stop_done),
    .oversize(oversize), .drop_ack(drop_ack)
  );

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 13 + i * 29 + 7) & 255);
  endfunction

  int ncyc = 0, rx_bits = 0, first_cyc = 0, last_cyc = 0;
  int ov_cnt = 0, ov_bit = -1, sd_cnt = 0, sd_cyc = 0, dr_cnt = 0, dr_cyc = 0;
  logic [7:0] rxb [0:63];

  always @(negedge clk) begin
    ncyc = ncyc + 1;
    if (tx_en) begin
      if (rx_bits == 0) first_cyc = ncyc;
      last_cyc = ncyc;
      if (oversize) begin ov_cnt++; ov_bit = rx_bits; end
      if (rx_bits < 512) rxb[rx_bits / 8][rx_bits % 8] = tx_d;
      rx_bits++;
    end else if (oversize) ov_cnt++;
    if (stop_done) begin sd_cnt++; sd_cyc = ncyc; end
    if (drop_ack) begin dr_cnt++; dr_cyc = ncyc; end
  end

  task automatic clear_mon();
    @(negedge clk); #1;
    rx_bits = 0; ov_cnt = 0; ov_bit = -1; sd_cnt = 0; dr_cnt = 0;
  endtask

  task automatic send_frame(input int seed, input int len, input int gap_at, input int gap_len);
    for (int i = 0; i < len; i++) begin
      bit acc;
      if (i == gap_at) begin
        in_valid = 1'b0;
        repeat (gap_len) @(negedge clk);
      end
      in_valid = 1'b1; in_data = pat(seed, i);
      in_sof = (i == 0); in_eof = (i == len - 1);
      do begin
        #1 acc = in_ready;
        @(posedge clk); @(negedge clk);
      end while (!acc);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic check_bytes(input int seed, input int len, input string req);
    int bad = 0;
    for (int i = 0; i < len; i++) if (rxb[i] !== pat(seed, i)) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!tx_en && !stop_done && !oversize && !drop_ack, "R1 outputs idle in reset", int'(tx_en), 0);
    chk(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!tx_en && !stop_done && !oversize && !drop_ack, "R1 outputs idle after reset", int'(tx_en), 0);

    // R2 / R7 sweep
    for (int len = 1; len <= 6; len++) begin
      for (int mx = 0; mx <= 6; mx++) begin
        max_len = 11'(mx);
        clear_mon();
        send_frame(len * 7 + mx, len, -1, 0);
        repeat (12) @(negedge clk);
        #1;
        chk(rx_bits == 8 * len, "R2 bit count", rx_bits, 8 * len);
        chk(last_cyc - first_cyc + 1 == 8 * len, "R2 contiguous span", last_cyc - first_cyc + 1, 8 * len);
        check_bytes(len * 7 + mx, len, "R2 lsb-first bytes");
        chk(ov_cnt == ((len > mx) ? 1 : 0), "R7 oversize count", ov_cnt, (len > mx) ? 1 : 0);
        if (len > mx) chk(ov_bit == 8 * mx, "R7 oversize position", ov_bit, 8 * mx);
      end
    end
    max_len = 11'd100;

    // R10: stray bytes while idle
    clear_mon();
    in_valid = 1'b1; in_data = 8'hA5; in_sof = 1'b0; in_eof = 1'b0;
    #1 chk(in_ready == 1'b1, "R10 stray byte accepted", int'(in_ready), 1);
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk); #1;
    chk(rx_bits == 0, "R10 stray bytes not sent", rx_bits, 0);

    // R8: collision while idle
    clear_mon();
    col = 1'b1; repeat (3) @(negedge clk); col = 1'b0;
    repeat (2) @(negedge clk); #1;
    chk(dr_cnt == 0, "R8 idle collision ignored", dr_cnt, 0);

    // R3 / R5 / R6: stop while idle
    clear_mon();
    stop_req = 1'b1;
    @(negedge clk); #1;
    chk(stop_done == 1'b1, "R3 stop_done next cycle", int'(stop_done), 1);
    chk(in_ready == 1'b0, "R3 not ready when stopped", int'(in_ready), 0);
    in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_data = 8'h3C;
    repeat (20) @(negedge clk); #1;
    chk(sd_cnt == 1, "R5 single stop pulse", sd_cnt, 1);
    chk(rx_bits == 0, "R3 no frame while stopped", rx_bits, 0);
    chk(in_ready == 1'b0, "R6 ready low while stopped", int'(in_ready), 0);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    stop_req = 1'b0;
    #1 chk(in_ready == 1'b0, "R6 still halted same cycle", int'(in_ready), 0);
    @(negedge clk); #1;
    chk(in_ready == 1'b1, "R6 ready after release", int'(in_ready), 1);
    send_frame(3, 2, -1, 0);
    repeat (20) @(negedge clk); #1;
    chk(rx_bits == 16, "R6 frame after resume", rx_bits, 16);
    check_bytes(3, 2, "R6 resume bytes");

    // R4: stop during frame
    clear_mon();
    fork
      send_frame(5, 4, -1, 0);
      begin repeat (10) @(negedge clk); stop_req = 1'b1; end
    join
    repeat (20) @(negedge clk); #1;
    chk(rx_bits == 32, "R4 frame completes", rx_bits, 32);
    check_bytes(5, 4, "R4 bytes intact");
    chk(sd_cnt == 1, "R4 one stop pulse", sd_cnt, 1);
    chk(sd_cyc == last_cyc + 1, "R4 stop after last bit", sd_cyc, last_cyc + 1);
    stop_req = 1'b0;
    repeat (2) @(negedge clk);

    // R8 / R10: collision mid-frame
    clear_mon();
    fork
      send_frame(9, 5, -1, 0);
      begin
        do begin @(negedge clk); #1; end while (rx_bits < 12);
        col = 1'b1;
        @(negedge clk); col = 1'b0; #1;
        chk(tx_en == 1'b0, "R8 tx off after collision", int'(tx_en), 0);
        chk(drop_ack == 1'b1, "R8 drop_ack after collision", int'(drop_ack), 1);
      end
    join
    repeat (20) @(negedge clk); #1;
    chk(rx_bits < 16, "R8 rest of frame not sent", rx_bits, 13);
    chk(dr_cnt == 1, "R8 one drop pulse", dr_cnt, 1);

    // R9: collision with pending stop
    clear_mon();
    fork
      send_frame(11, 5, -1, 0);
      begin
        do begin @(negedge clk); #1; end while (rx_bits < 10);
        stop_req = 1'b1;
        repeat (3) @(negedge clk);
        col = 1'b1;
        @(negedge clk); col = 1'b0; #1;
        chk(stop_done == 1'b1, "R9 stop with collision", int'(stop_done), 1);
        chk(drop_ack == 1'b1, "R9 drop with stop", int'(drop_ack), 1);
        repeat (5) @(negedge clk);
        stop_req = 1'b0;
      end
    join
    repeat (10) @(negedge clk); #1;
    chk(sd_cnt == 1 && sd_cyc == dr_cyc, "R9 pulses coincide", sd_cyc, dr_cyc);

    // R11: late byte
    clear_mon();
    fork
      send_frame(13, 4, 2, 12);
      begin
        do begin @(negedge clk); #1; end while (rx_bits < 16);
        @(negedge clk); #1;
        chk(!tx_en && in_ready, "R11 waiting for late byte", int'(tx_en), 0);
      end
    join
    repeat (40) @(negedge clk); #1;
    chk(rx_bits == 32, "R11 bit count", rx_bits, 32);
    check_bytes(13, 4, "R11 bytes intact");
    chk(last_cyc - first_cyc + 1 == 32 + 12 - 7, "R11 stall length", last_cyc - first_cyc + 1, 37);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule